// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent virtual-page to physical-frame translations and answers a lookup in the same cycle it is presented. A lookup carries a virtual page number, a page offset and a write flag. When a valid entry holds that page, the block reports a hit and drives the physical address, which is the cached frame number joined with the unchanged offset. Otherwise it reports a miss, and an external table walker later supplies the translation through the refill port.

Any entry may hold any page. A refill first fills the lowest-numbered empty slot. When every slot is in use, it replaces the least recently used one, where both hits and refills count as uses. Each entry carries a dirty flag. The first write that hits a clean entry sets the flag and raises a one-cycle strobe carrying the page number, so that the walker can mark the page-table entry as modified. A flush input empties the whole array in one cycle.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss.
- R2: A lookup (`lookupValid`=1) whose page matches a valid entry drives `hit`=1 in the same cycle, with `physAddr` = {frame, offset}, the frame in the upper 20 bits and the offset in the lower 12 bits.
- R3: A lookup with no matching valid entry drives `miss`=1, `hit`=0 and `physAddr`=0. `hit` and `miss` are never high together.
- R4: A refill (`refillValid`=1 without `flush`) installs the page, the frame and the given dirty flag at the clock edge. A lookup of that page in the next cycle hits.
- R5: While an empty slot exists, a refill goes into the lowest-numbered empty slot, so sixteen distinct refills after reset or a flush evict nothing.
- R6: When all slots are valid, a refill of a new page replaces the least recently used entry. Each hit and each refill makes its entry the most recently used.
- R7: A write lookup that hits a clean entry raises `dirtyUpdValid` in the same cycle with `dirtyUpdVpn` equal to the page, and marks the entry dirty.
- R8: A write hit on a dirty entry, any read hit, and any miss leave `dirtyUpdValid` low. An entry refilled with `refillDirty`=1 counts as dirty.
- R9: `flush` invalidates every entry at the clock edge. Every lookup in the following cycle misses.
- R10: A refill of a page that is already present overwrites that entry with the new frame, and all other entries are kept.
- R11: In a cycle with `refill` or `flush` high, a lookup is ignored. `hit`, `miss` and `dirtyUpdValid` stay 0, and neither the dirty state nor the use order changes. `flush` wins over `refill`.
- R12: At most one valid entry ever matches a given page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | 20 | Virtual page number to translate |
| lookupOffset | input | 12 | Page offset passed into the physical address |
| lookupWrite | input | 1 | Lookup is for a store |
| hit | output | 1 | Lookup found a translation |
| miss | output | 1 | Lookup found no translation |
| physAddr | output | 32 | {frame, offset} on a hit, 0 otherwise |
| dirtyUpdValid | output | 1 | First write to a clean entry |
| dirtyUpdVpn | output | 20 | Page whose dirty flag was just set |
| refillValid | input | 1 | Install a translation |
| refillVpn | input | 20 | Page to install |
| refillPfn | input | 20 | Frame number to install |
| refillDirty | input | 1 | Dirty state of the installed translation |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions assume that the walker never relies on a lookup made in the same cycle as a refill or a flush. They also assume that refills arrive only through the refill port, which keeps the age ordering a permutation and every page in at most one entry. The random stimulus draws pages from a pool of 24, larger than the array, so that hits, misses, overwrites and evictions all occur. It keeps lookups, refills and flushes in separate cycles. One directed case overlaps a write lookup with a refill and then confirms through later lookups that the write left no trace.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // strobes from control to the entry array
  typedef struct packed {
    logic doFlush;
    logic doInstall;
    logic installDirty;
    logic doTouch;
    logic doSetDirty;
  } ctrlStrobes_t;
endpackage

// File: rtl/xlate_array.sv
module xlate_array
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     st,
  input  logic [IDX_W-1:0] installIdx,
  input  logic [IDX_W-1:0] touchIdx,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  output logic             matchAny,
  output logic [IDX_W-1:0] hitIdx,
  output logic [PFN_W-1:0] hitPfn,
  output logic             hitDirty,
  output logic             refMatchAny,
  output logic [IDX_W-1:0] refMatchIdx,
  output logic             freeAny,
  output logic [IDX_W-1:0] freeIdx,
  output logic [IDX_W-1:0] lruIdx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] dirtyVec;
  logic [VPN_W-1:0]   tagMem [ENTRIES];
  logic [PFN_W-1:0]   pfnMem [ENTRIES];
  logic [IDX_W-1:0]   age    [ENTRIES];

  logic [ENTRIES-1:0] matchVec, refVec, lruVec;

  // compare every entry against both page numbers
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = validVec[g] && (tagMem[g] == lookupVpn);
    assign refVec[g]   = validVec[g] && (tagMem[g] == refillVpn);
    assign lruVec[g]   = (age[g] == OLDEST);
  end

  // lowest-index encoders
  always_comb begin
    hitIdx      = '0;
    refMatchIdx = '0;
    freeIdx     = '0;
    lruIdx      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])  hitIdx      = IDX_W'(i);
      if (refVec[i])    refMatchIdx = IDX_W'(i);
      if (!validVec[i]) freeIdx     = IDX_W'(i);
      if (lruVec[i])    lruIdx      = IDX_W'(i);
    end
  end

  assign matchAny    = |matchVec;
  assign refMatchAny = |refVec;
  assign freeAny     = ~&validVec;
  assign hitPfn      = pfnMem[hitIdx];
  assign hitDirty    = dirtyVec[hitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      dirtyVec <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i] <= '0;
        pfnMem[i] <= '0;
        age[i]    <= IDX_W'(i);
      end
    end else if (st.doFlush) begin
      validVec <= '0;
    end else begin
      if (st.doInstall) begin
        validVec[installIdx] <= 1'b1;
        tagMem[installIdx]   <= refillVpn;
        pfnMem[installIdx]   <= refillPfn;
        dirtyVec[installIdx] <= st.installDirty;
      end
      if (st.doSetDirty) dirtyVec[touchIdx] <= 1'b1;
      if (st.doTouch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)       age[i] <= '0;
          else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R12
  AST_REFILL_NO_DUP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(refVec)); // R10
  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lruVec) == 1); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    st.doFlush |=> (validVec == '0)); // R9
  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    st.doInstall |=> validVec[$past(installIdx)]); // R4
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             refillValid,
  input  logic             refillDirty,
  input  logic             flush,
  input  logic             matchAny,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             hitDirty,
  input  logic             refMatchAny,
  input  logic [IDX_W-1:0] refMatchIdx,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic [IDX_W-1:0] lruIdx,
  output ctrlStrobes_t     st,
  output logic [IDX_W-1:0] installIdx,
  output logic [IDX_W-1:0] touchIdx,
  output logic             hit,
  output logic             miss,
  output logic             dirtyUpdValid,
  output logic [VPN_W-1:0] dirtyUpdVpn
);
  logic busy, lookupGo;

  assign busy     = flush || refillValid;
  assign lookupGo = lookupValid && !busy;
  assign hit      = lookupGo && matchAny;
  assign miss     = lookupGo && !matchAny;

  // victim choice: existing copy, then empty slot, then oldest
  always_comb begin
    if (refMatchAny)  installIdx = refMatchIdx;
    else if (freeAny) installIdx = freeIdx;
    else              installIdx = lruIdx;
  end

  always_comb begin
    st.doFlush      = flush;
    st.doInstall    = refillValid && !flush;
    st.installDirty = refillDirty;
    st.doSetDirty   = hit && lookupWrite && !hitDirty;
    st.doTouch      = st.doInstall || hit;
  end

  assign touchIdx      = st.doInstall ? installIdx : hitIdx;
  assign dirtyUpdValid = st.doSetDirty;
  assign dirtyUpdVpn   = st.doSetDirty ? lookupVpn : '0;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss)); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(hit || miss || dirtyUpdValid)); // R11
  AST_STROBE_ON_WRITE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    dirtyUpdValid |-> (hit && lookupWrite)); // R7
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOffset,
  input  logic                   lookupWrite,
  output logic                   hit,
  output logic                   miss,
  output logic [PFN_W+OFF_W-1:0] physAddr,
  output logic                   dirtyUpdValid,
  output logic [VPN_W-1:0]       dirtyUpdVpn,
  input  logic                   refillValid,
  input  logic [VPN_W-1:0]       refillVpn,
  input  logic [PFN_W-1:0]       refillPfn,
  input  logic                   refillDirty,
  input  logic                   flush
);
  localparam int IDX_W = $clog2(ENTRIES);

  ctrlStrobes_t     st;
  logic [IDX_W-1:0] installIdx, touchIdx, hitIdx, refMatchIdx, freeIdx, lruIdx;
  logic             matchAny, hitDirty, refMatchAny, freeAny;
  logic [PFN_W-1:0] hitPfn;

  xlate_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
    .clk(clk), .rstN(rstN), .st(st), .installIdx(installIdx), .touchIdx(touchIdx),
    .lookupVpn(lookupVpn), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .matchAny(matchAny), .hitIdx(hitIdx), .hitPfn(hitPfn), .hitDirty(hitDirty),
    .refMatchAny(refMatchAny), .refMatchIdx(refMatchIdx),
    .freeAny(freeAny), .freeIdx(freeIdx), .lruIdx(lruIdx)
  );

  xlate_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVpn(lookupVpn), .refillValid(refillValid), .refillDirty(refillDirty),
    .flush(flush), .matchAny(matchAny), .hitIdx(hitIdx), .hitDirty(hitDirty),
    .refMatchAny(refMatchAny), .refMatchIdx(refMatchIdx), .freeAny(freeAny),
    .freeIdx(freeIdx), .lruIdx(lruIdx), .st(st), .installIdx(installIdx),
    .touchIdx(touchIdx), .hit(hit), .miss(miss), .dirtyUpdValid(dirtyUpdValid),
    .dirtyUpdVpn(dirtyUpdVpn)
  );

  assign physAddr = hit ? {hitPfn, lookupOffset} : '0;
endmodule

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  localparam int N = 16;
  localparam int POOL = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic [11:0] lookupOffset = '0;
  logic        hit, miss, dirtyUpdValid;
  logic [31:0] physAddr;
  logic [19:0] dirtyUpdVpn;
  logic        refillValid = 1'b0, refillDirty = 1'b0, flush = 1'b0;
  logic [19:0] refillVpn = '0, refillPfn = '0;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  // reference model, built from the requirements
  bit          mV [N];
  logic [19:0] mT [N];
  logic [19:0] mP [N];
  bit          mD [N];
  int          mA [N];

  always #10 clk = ~clk;

  xlate_cache u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupOffset(lookupOffset), .lookupWrite(lookupWrite), .hit(hit), .miss(miss),
    .physAddr(physAddr), .dirtyUpdValid(dirtyUpdValid), .dirtyUpdVpn(dirtyUpdVpn),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillDirty(refillDirty), .flush(flush)
  );

  function automatic logic [19:0] poolVpn(int k);
    return 20'h10000 + 20'(k * 37);
  endfunction

  function automatic int mFind(logic [19:0] v);
    for (int i = 0; i < N; i++) if (mV[i] && mT[i] == v) return i;
    return -1;
  endfunction

  function automatic void mTouch(int k);
    int old = mA[k];
    for (int i = 0; i < N; i++) begin
      if (i == k) mA[i] = 0;
      else if (mA[i] < old) mA[i] = mA[i] + 1;
    end
  endfunction

  function automatic void mReset();
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mD[i] = 0; mA[i] = i; mT[i] = '0; mP[i] = '0;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doLookup(input logic [19:0] v, input logic [11:0] off, input bit wr, input string req);
    int k;
    bit expHit, expStr;
    logic [31:0] expPa;
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = v; lookupOffset = off; lookupWrite = wr;
    #1;
    k = mFind(v);
    expHit = (k >= 0);
    expPa  = expHit ? {mP[k], off} : 32'h0;
    expStr = expHit && wr && !mD[k];
    chk(hit == expHit && miss == !expHit, req, {hit, miss}, {expHit, !expHit});
    chk(physAddr == expPa, req, physAddr, expPa);
    chk(dirtyUpdValid == expStr && (!expStr || dirtyUpdVpn == v), req,
        {dirtyUpdValid, dirtyUpdVpn}, {expStr, expStr ? v : 20'h0});
    @(posedge clk);
    #1;
    lookupValid = 1'b0; lookupWrite = 1'b0;
    if (expHit) begin
      if (wr) mD[k] = 1;
      mTouch(k);
    end
  endtask

  function automatic void mInstall(logic [19:0] v, logic [19:0] p, bit d);
    int k = mFind(v);
    if (k < 0) for (int i = N - 1; i >= 0; i--) if (!mV[i]) k = i;
    if (k < 0) for (int i = 0; i < N; i++) if (mA[i] == N - 1) k = i;
    mV[k] = 1; mT[k] = v; mP[k] = p; mD[k] = d;
    mTouch(k);
  endfunction

  task automatic doRefill(input logic [19:0] v, input logic [19:0] p, input bit d);
    @(negedge clk);
    refillValid = 1'b1; refillVpn = v; refillPfn = p; refillDirty = d;
    @(posedge clk);
    #1;
    refillValid = 1'b0;
    mInstall(v, p, d);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    for (int i = 0; i < N; i++) mV[i] = 0;
  endtask

  task automatic sweepPool(input string req);
    for (int k = 0; k < POOL; k++) doLookup(poolVpn(k), 12'h5a5, 1'b0, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: empty after reset
    doLookup(poolVpn(0), 12'h123, 1'b0, "R1 reset miss");
    doLookup(poolVpn(5), 12'h000, 1'b1, "R1 reset write miss");

    // R4 / R2: refill then hit with joined address
    doRefill(poolVpn(0), 20'hABCDE, 1'b0);
    doLookup(poolVpn(0), 12'hFFF, 1'b0, "R2 R4 hit after refill");
    doLookup(poolVpn(1), 12'h001, 1'b0, "R3 miss other page");

    // R7 / R8: dirty strobe once
    doLookup(poolVpn(0), 12'h010, 1'b1, "R7 first write strobe");
    doLookup(poolVpn(0), 12'h020, 1'b1, "R8 second write quiet");
    doRefill(poolVpn(2), 20'h00222, 1'b1);
    doLookup(poolVpn(2), 12'h030, 1'b1, "R8 refilled dirty quiet");

    // R10: overwrite existing page
    doRefill(poolVpn(0), 20'h13579, 1'b0);
    doLookup(poolVpn(0), 12'h040, 1'b0, "R10 new frame");
    doLookup(poolVpn(2), 12'h050, 1'b0, "R10 neighbour kept");

    // R11: lookup overlapped with refill is ignored
    doRefill(poolVpn(3), 20'h03333, 1'b0);
    @(negedge clk);
    lookupValid = 1'b1; lookupWrite = 1'b1; lookupVpn = poolVpn(3);
    refillValid = 1'b1; refillVpn = poolVpn(4); refillPfn = 20'h04444; refillDirty = 1'b0;
    #1;
    chk(!hit && !miss && !dirtyUpdValid, "R11 busy quiet", {hit, miss, dirtyUpdValid}, 3'b000);
    @(posedge clk);
    #1;
    lookupValid = 1'b0; lookupWrite = 1'b0; refillValid = 1'b0;
    mInstall(poolVpn(4), 20'h04444, 1'b0);
    doLookup(poolVpn(3), 12'h060, 1'b1, "R11 dirty untouched");

    // R9: flush
    doFlush();
    sweepPool("R9 all miss after flush");

    // R5: sixteen refills evict nothing
    for (int k = 0; k < N; k++) doRefill(poolVpn(k), 20'(k * 4099 + 7), 1'b0);
    sweepPool("R5 all sixteen resident");

    // R6: reuse a few, then evict
    doLookup(poolVpn(0), 12'h0, 1'b0, "R6 touch");
    doLookup(poolVpn(1), 12'h0, 1'b0, "R6 touch");
    doRefill(poolVpn(16), 20'h16161, 1'b0);
    doRefill(poolVpn(17), 20'h17171, 1'b0);
    sweepPool("R6 oldest evicted");

    // random mix checked against the model
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 99));
      logic [19:0] v = poolVpn(int'($urandom_range(0, POOL - 1)));
      if (op < 60)
        doLookup(v, 12'($urandom), bit'($urandom_range(0, 1)), "R2 R3 R6 R7 random");
      else if (op < 98)
        doRefill(v, 20'($urandom), bit'($urandom_range(0, 3) == 0));
      else
        doFlush();
    end
    sweepPool("R6 R10 final sweep");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule